// File: doc/BRIEF.md
# Processor Interrupt Interface with Acknowledge and Nesting

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers the best pending interrupt for this processor: an ID, a source processor number and an 8-bit priority. The block compares that priority against two thresholds. The first is a programmable priority mask. The second is the running priority of the interrupt now being serviced. If the interrupt beats both thresholds and the interface is enabled, the block raises an interrupt request to the processor.

Software on the processor uses a small register map. Reading the acknowledge register returns the pending interrupt and activates it as a side effect. The interrupt's priority is pushed onto a stack of active priorities and becomes the new running priority. Writing that same value to the end-of-interrupt register pops the stack, which restores the priority that was running before. If nothing qualifies, the acknowledge read returns the spurious ID 1023 and changes no state. Lower numeric values mean higher priority, and only the upper `PRIO_BITS` bits of a priority take part in any compare.

The distributor sees each activation as a one-cycle `act_valid` pulse and each completion as a one-cycle `done_valid` pulse. Both pulses come in the same cycle as the register access that causes them. They carry no back-pressure, so the distributor must accept every pulse. The register port is a plain single-cycle strobe. `reg_rdata` is valid combinationally while `reg_rd` is high, and any side effect takes place at the clock edge that ends the access.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the control and mask registers read 0, `irq_o` is low and the running priority reads 0xFF.
- R2: Bit 0 of the control register (offset 0x00) enables the request. While it is 0, `irq_o` stays low whatever is pending.
- R3: The mask register (offset 0x04) keeps only its upper 4 bits (with PRIO_BITS=4). Its lower bits always read 0.
- R4: `irq_o` is high when the interface is enabled, `pend_valid` is 1, and the pending priority with its lower 4 bits cleared is strictly lower than both the mask and the running priority. An equal value does not qualify.
- R5: An acknowledge read (offset 0x0C) of a qualifying interrupt returns the source in bits 12:10 and the ID in bits 9:0. It pulses `act_valid` with that ID, and after the access the running priority equals the pending priority with its lower 4 bits cleared.
- R6: An acknowledge read with nothing qualifying returns 1023 (bits 12:10 zero). It gives no `act_valid` pulse and leaves the running priority unchanged.
- R7: A write to offset 0x10 whose bits 12:0 equal the most recently acknowledged value pulses `done_valid` with that ID and restores the previous running priority.
- R8: An end-of-interrupt write whose value does not match the most recently acknowledged active interrupt is ignored: no `done_valid`, and the running priority is unchanged.
- R9: Offset 0x14 reads the running priority, which is 0xFF when no interrupt is active.
- R10: Offset 0x18 reads the pending source and ID, in the same layout as the acknowledge register, when `pend_valid` is 1 and 1023 otherwise. This read has no side effect.
- R11: Offset 0xFC reads the `IFACE_ID` parameter.
- R12: While the stack holds `STACK_DEPTH` active interrupts, `irq_o` is low and acknowledge reads return 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| pend_valid | input | 1 | A pending interrupt is offered |
| pend_id | input | 10 | Pending interrupt ID |
| pend_src | input | 3 | Source processor of the pending interrupt |
| pend_prio | input | 8 | Pending interrupt priority |
| irq_o | output | 1 | Interrupt request to the processor |
| act_valid | output | 1 | Activation pulse to the distributor |
| act_id | output | 10 | ID being activated |
| act_src | output | 3 | Source of the ID being activated |
| done_valid | output | 1 | Completion pulse to the distributor |
| done_id | output | 10 | ID being completed |
| done_src | output | 3 | Source of the ID being completed |

## Verification
The bench drives three kinds of pending priority against the mask and running priority. A priority below both thresholds must raise the request. A priority equal to a threshold must not, which exposes a non-strict compare. A priority that differs from a threshold only in its lower four bits shows whether those bits are wrongly compared. A two-level nesting sequence acknowledges a lower-priority interrupt and then a higher one. It then ends them with a mismatched and then matching end-of-interrupt writes, to tell a stack from a single saved priority. Filling the stack to its depth and an acknowledge read with nothing pending check the spurious path and the limit.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int ID_W   = 10;
  localparam int SRC_W  = 3;
  localparam int PRIO_W = 8;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RUN  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_HIGH = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_IDNT = 8'hFC;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [SRC_W-1:0]  src;
    logic [ID_W-1:0]   id;
  } act_entry_t;
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify
  import cpu_irq_pkg::*;
#(
  parameter int PRIO_BITS = 4
) (
  input  logic              enable,
  input  logic              pend_valid,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W-1:0] mask,
  input  logic [PRIO_W-1:0] running,
  input  logic              stack_full,
  output logic [PRIO_W-1:0] prio_eff,
  output logic              qualifies
);
  localparam logic [PRIO_W-1:0] KEEP = ~((PRIO_W'(1) << (PRIO_W - PRIO_BITS)) - PRIO_W'(1));

  always_comb begin
    prio_eff  = pend_prio & KEEP;
    qualifies = enable && pend_valid && !stack_full &&
                (prio_eff < mask) && (prio_eff < running);
  end
endmodule

// File: rtl/prio_stack.sv
module prio_stack
  import cpu_irq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  act_entry_t push_entry,
  input  logic       pop,
  output act_entry_t top_entry,
  output logic       empty,
  output logic       full
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  act_entry_t       slot_q [DEPTH];
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] top_ix;
  logic [CNT_W-1:0] wr_ix;

  assign empty  = (count_q == '0);
  assign full   = (count_q == CNT_W'(DEPTH));
  assign top_ix = count_q - CNT_W'(1);
  assign wr_ix  = count_q;

  always_comb begin
    if (empty) begin
      top_entry      = '0;
      top_entry.prio = IDLE_PRIO;
      top_entry.id   = SPURIOUS_ID;
    end else begin
      top_entry = slot_q[top_ix[IDX_W-1:0]];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q[g] <= '0;
      else if (push && !full && wr_ix == CNT_W'(g)) slot_q[g] <= push_entry;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else if (push && !full) count_q <= count_q + CNT_W'(1);
    else if (pop && !empty) count_q <= count_q - CNT_W'(1);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH)); // R12
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (count_q == $past(count_q) + CNT_W'(1))); // R5
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> (count_q == $past(count_q) - CNT_W'(1))); // R7
endmodule

// File: rtl/cpu_irq_iface.sv
module cpu_irq_iface
  import cpu_irq_pkg::*;
#(
  parameter int          STACK_DEPTH = 4,
  parameter int          PRIO_BITS   = 4,
  parameter logic [31:0] IFACE_ID    = 32'h0002_1A5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pend_valid,
  input  logic [ID_W-1:0]   pend_id,
  input  logic [SRC_W-1:0]  pend_src,
  input  logic [PRIO_W-1:0] pend_prio,
  output logic              irq_o,
  output logic              act_valid,
  output logic [ID_W-1:0]   act_id,
  output logic [SRC_W-1:0]  act_src,
  output logic              done_valid,
  output logic [ID_W-1:0]   done_id,
  output logic [SRC_W-1:0]  done_src
);
  localparam int VAL_W = ID_W + SRC_W;
  localparam logic [PRIO_W-1:0] KEEP = ~((PRIO_W'(1) << (PRIO_W - PRIO_BITS)) - PRIO_W'(1));

  logic              ctrl_en_q;
  logic [PRIO_W-1:0] mask_q;
  logic [PRIO_W-1:0] prio_eff;
  logic              qualifies;
  logic              stk_empty, stk_full;
  act_entry_t        top_entry, push_entry;
  logic [PRIO_W-1:0] running;
  logic              ack_rd, ack_take, eoi_wr, eoi_match;
  logic [VAL_W-1:0]  ack_val, high_val;

  assign running = top_entry.prio;

  irq_qualify #(.PRIO_BITS(PRIO_BITS)) u_qual (
    .enable    (ctrl_en_q),
    .pend_valid(pend_valid),
    .pend_prio (pend_prio),
    .mask      (mask_q),
    .running   (running),
    .stack_full(stk_full),
    .prio_eff  (prio_eff),
    .qualifies (qualifies)
  );

  assign ack_rd    = reg_rd && (reg_addr == OFS_ACK);
  assign ack_take  = ack_rd && qualifies;
  assign eoi_wr    = reg_wr && (reg_addr == OFS_EOI);
  assign eoi_match = eoi_wr && !stk_empty &&
                     (reg_wdata[VAL_W-1:0] == {top_entry.src, top_entry.id});

  always_comb begin
    push_entry.prio = prio_eff;
    push_entry.src  = pend_src;
    push_entry.id   = pend_id;
  end

  prio_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ack_take),
    .push_entry(push_entry),
    .pop       (eoi_match),
    .top_entry (top_entry),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q <= 1'b0;
      mask_q    <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_CTRL) ctrl_en_q <= reg_wdata[0];
      if (reg_addr == OFS_MASK) mask_q    <= reg_wdata[PRIO_W-1:0] & KEEP;
    end
  end

  assign ack_val  = qualifies  ? {pend_src, pend_id} : {{SRC_W{1'b0}}, SPURIOUS_ID};
  assign high_val = pend_valid ? {pend_src, pend_id} : {{SRC_W{1'b0}}, SPURIOUS_ID};

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      unique case (reg_addr)
        OFS_CTRL: reg_rdata[0]          = ctrl_en_q;
        OFS_MASK: reg_rdata[PRIO_W-1:0] = mask_q;
        OFS_ACK:  reg_rdata[VAL_W-1:0]  = ack_val;
        OFS_RUN:  reg_rdata[PRIO_W-1:0] = running;
        OFS_HIGH: reg_rdata[VAL_W-1:0]  = high_val;
        OFS_IDNT: reg_rdata             = IFACE_ID;
        default:  reg_rdata             = '0;
      endcase
    end
  end

  assign irq_o      = qualifies;
  assign act_valid  = ack_take;
  assign act_id     = pend_id;
  assign act_src    = pend_src;
  assign done_valid = eoi_match;
  assign done_id    = top_entry.id;
  assign done_src   = top_entry.src;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ctrl_en_q); // R2
  AST_RUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stk_empty |-> (running == IDLE_PRIO)); // R9
  AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> (running == $past(prio_eff))); // R5
  AST_SPUR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !qualifies && !eoi_wr) |=> $stable(running)); // R6
  AST_EOI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_wr && !eoi_match && !ack_rd) |=> $stable(running)); // R8
  AST_MASK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q & ~KEEP) == '0); // R3
endmodule

// File: tb/test_cpu_irq_iface.sv
`timescale 1ns/1ps
module test_cpu_irq_iface;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_rd = 0, reg_wr = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        pend_valid = 0;
  logic [9:0]  pend_id = 0;
  logic [2:0]  pend_src = 0;
  logic [7:0]  pend_prio = 0;
  logic        irq_o, act_valid, done_valid;
  logic [9:0]  act_id, done_id;
  logic [2:0]  act_src, done_src;

  int checks = 0, fails = 0;
  logic        seen_act, seen_done;
  logic [9:0]  seen_done_id;

  always #5 clk = ~clk;

  cpu_irq_iface i_cpu_irq_iface (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pend_valid(pend_valid), .pend_id(pend_id), .pend_src(pend_src),
    .pend_prio(pend_prio), .irq_o(irq_o), .act_valid(act_valid),
    .act_id(act_id), .act_src(act_src), .done_valid(done_valid),
    .done_id(done_id), .done_src(done_src)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata; seen_act = act_valid;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    #1 seen_done = done_valid; seen_done_id = done_id;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic offer(input logic v, input logic [9:0] id, input logic [2:0] s, input logic [7:0] p);
    @(negedge clk);
    pend_valid = v; pend_id = id; pend_src = s; pend_prio = p;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", {31'd0, irq_o}, 0);
    rd(8'h00, d); check("R1 ctrl", d, 0);
    rd(8'h04, d); check("R1 mask", d, 0);
    rd(8'h14, d); check("R1 running", d, 32'hFF);
  endtask

  task automatic t_ctrl_mask;
    logic [31:0] d;
    wr(8'h04, 32'h0000_00F7);
    rd(8'h04, d); check("R3 mask low bits", d, 32'hF0);
    offer(1, 10'd9, 3'd0, 8'h20);
    check("R2 disabled no irq", {31'd0, irq_o}, 0);
    wr(8'h00, 1);
    rd(8'h00, d); check("R2 ctrl bit", d, 1);
    #1 check("R2 enabled irq", {31'd0, irq_o}, 1);
  endtask

  task automatic t_compare;
    offer(1, 10'd9, 3'd0, 8'hF0);
    check("R4 equal to mask", {31'd0, irq_o}, 0);
    offer(1, 10'd9, 3'd0, 8'hEF);
    check("R4 below mask", {31'd0, irq_o}, 1);
    offer(1, 10'd9, 3'd0, 8'hF5);
    check("R4 low bits ignored", {31'd0, irq_o}, 0);
    offer(0, 10'd9, 3'd0, 8'h10);
    check("R4 no pending", {31'd0, irq_o}, 0);
  endtask

  task automatic t_nest;
    logic [31:0] d;
    offer(1, 10'd5, 3'd1, 8'h8C);
    rd(8'h0C, d);
    check("R5 ack value", d, 32'h405);
    check("R5 act pulse", {31'd0, seen_act}, 1);
    rd(8'h14, d); check("R5 running", d, 32'h80);
    offer(1, 10'd7, 3'd2, 8'h83);
    check("R4 equal to running", {31'd0, irq_o}, 0);
    offer(1, 10'd7, 3'd2, 8'h70);
    check("R4 beats running", {31'd0, irq_o}, 1);
    rd(8'h0C, d); check("R5 nested ack", d, 32'h807);
    rd(8'h14, d); check("R5 nested running", d, 32'h70);
    wr(8'h10, 32'h405);
    check("R8 no done", {31'd0, seen_done}, 0);
    rd(8'h14, d); check("R8 running kept", d, 32'h70);
    wr(8'h10, 32'h807);
    check("R7 done pulse", {31'd0, seen_done}, 1);
    check("R7 done id", {22'd0, seen_done_id}, 32'd7);
    rd(8'h14, d); check("R7 restored", d, 32'h80);
    wr(8'h10, 32'h405);
    rd(8'h14, d); check("R9 idle", d, 32'hFF);
  endtask

  task automatic t_spurious;
    logic [31:0] d;
    offer(0, 10'd3, 3'd4, 8'h10);
    rd(8'h0C, d); check("R6 spurious", d, 32'd1023);
    check("R6 no act", {31'd0, seen_act}, 0);
    rd(8'h14, d); check("R6 running", d, 32'hFF);
    rd(8'h18, d); check("R10 none", d, 32'd1023);
    offer(1, 10'd44, 3'd3, 8'hFF);
    rd(8'h18, d); check("R10 pending", d, {19'd0, 3'd3, 10'd44});
    rd(8'h14, d); check("R10 no side effect", d, 32'hFF);
    rd(8'hFC, d); check("R11 ident", d, 32'h0002_1A5C);
  endtask

  task automatic t_full;
    logic [31:0] d;
    for (int k = 0; k < 4; k++) begin
      offer(1, 10'(20 + k), 3'd0, 8'(8'h80 - 8'(k * 16)));
      rd(8'h0C, d); check("R12 fill ack", d, 32'(20 + k));
    end
    rd(8'h14, d); check("R12 running at full", d, 32'h50);
    offer(1, 10'd30, 3'd0, 8'h10);
    check("R12 no irq when full", {31'd0, irq_o}, 0);
    rd(8'h0C, d); check("R12 spurious when full", d, 32'd1023);
    for (int k = 3; k >= 0; k--) wr(8'h10, 32'(20 + k));
    rd(8'h14, d); check("R12 drained", d, 32'hFF);
  endtask

  initial begin
    fork
      begin
        #1; t_reset_wrap();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic t_reset_wrap;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_ctrl_mask();
    t_compare();
    t_nest();
    t_spurious();
    t_full();
  endtask
endmodule